// File: doc/BRIEF.md
# Interleaved Memory Bank Controller

This block is one of two controllers that sit on a shared word-addressed memory bus. The bus groups addresses into blocks of four consecutive words, and each controller answers only the word positions it has been configured for. A two-bit mode input selects the layout. In flat mode the controller owns every position. In the two interleaved modes it owns only the positions whose low address bit matches its odd/even strap. In the four-way mode each access also starts the partner module of a module pair, because both words that this controller owns in the block sit in that pair.

Behind the bus sit up to four equal storage modules. Each is a small on-chip array that holds 36 data bits and one odd-parity bit per word. A slot-present mask removes missing modules from the address space. Core timing is replaced by a fixed-latency handshake. The requester holds its request until it sees a one-cycle acknowledge. The acknowledge comes a fixed number of cycles after acceptance. The module then stays busy until its full cycle time has passed.

Top module: `ilv_bank_ctrl`

## Requirements
- R1: While reset is held and after it is released, `bus_ack`, `bus_perr` and `bus_rdata` are all zero until the first acknowledge.
- R2: `cfg_mode` selects the ownership rule. 0 is flat and owns every address. 1 is two-way and 2 is four-way, and both own only addresses whose bit 0 equals `cfg_odd`. 3 is off and owns nothing.
- R3: A local index is formed from the address: the address itself in flat mode, or the address shifted right by one in the interleaved modes. The module is the index modulo NUM_MOD, and the row is the index divided by NUM_MOD. An index of NUM_MOD*ROWS or more is not owned.
- R4: An address that maps to a module whose bit in `cfg_slots` is 0 is not owned.
- R5: An owned request that finds its modules idle is accepted at a clock edge. `bus_ack` is then high for exactly one cycle, starting ACC_DLY edges after that acceptance edge. Only one access is in progress at a time.
- R6: A read returns on `bus_rdata` the 36 data bits most recently written to the same module and row, together with the acknowledge.
- R7: Writes store odd parity, so that the 37 stored bits have an odd count of ones. When `bus_par_flip` is set, the parity bit is stored inverted. A read whose stored word fails the check raises `bus_perr` together with its acknowledge. A read of a good word and every write leave `bus_perr` low.
- R8: A module accepted at edge k accepts no new access before edge k+CYC_LEN. A back-to-back request to the same module is acknowledged CYC_LEN cycles after it is raised.
- R9: In four-way mode an access also occupies the partner module, whose index is the addressed index with bit 0 inverted, if that module is present. In the other modes the partner module stays free.
- R10: A request that is not owned produces no acknowledge and changes no stored word.
- R11: A request raised in the cycle after an acknowledge, to an idle module, is acknowledged ACC_DLY+1 cycles after it is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Layout: 0 flat, 1 two-way, 2 four-way, 3 off |
| cfg_odd | input | 1 | Strap: owned value of address bit 0 in the interleaved modes |
| cfg_slots | input | NUM_MOD | Present mask for the storage module slots |
| bus_req | input | 1 | Request, held until acknowledge |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_wdata | input | DATA_W | Write data |
| bus_par_flip | input | 1 | Store the parity bit inverted on this write |
| bus_rdata | output | DATA_W | Read data, valid with the acknowledge |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_perr | output | 1 | Parity error on the acknowledged read |

## Verification
The same stored words are read back under flat, two-way even, two-way odd and four-way layouts. This shows whether the index shift, the strap compare and the module and row split agree across modes. Each mode is also given addresses of the wrong parity, out-of-range addresses and addresses of absent slots, and each of these is followed by a read of the location it would have hit. This separates "ignored" from "silently written". The latency of back-to-back pairs is measured in three cases: the same module, the four-way partner module, and an unrelated module. This tells the per-module recovery apart from the pair launch and from a controller-wide stall. A word written with inverted parity shows that the error flag follows the stored bit and not the returned data.

// File: rtl/ibc_pkg.sv
package ibc_pkg;

  typedef enum logic [1:0] {
    LAYOUT_FLAT = 2'd0,
    LAYOUT_TWO  = 2'd1,
    LAYOUT_FOUR = 2'd2,
    LAYOUT_OFF  = 2'd3
  } layout_e;

  function automatic logic layout_split(input layout_e m);
    return (m == LAYOUT_TWO) || (m == LAYOUT_FOUR);
  endfunction

endpackage

// File: rtl/ibc_addr_map.sv
module ibc_addr_map
  import ibc_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int ROWS    = 16,
  parameter int NUM_MOD = 4,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int MOD_W  = $clog2(NUM_MOD)
) (
  input  layout_e              layout,
  input  logic                 odd_sel,
  input  logic [NUM_MOD-1:0]   slots,
  input  logic [ADDR_W-1:0]    addr,
  output logic                 hit,
  output logic [MOD_W-1:0]     mod_idx,
  output logic [ROW_W-1:0]     row_idx,
  output logic [NUM_MOD-1:0]   launch
);

  localparam int SPAN_W = ROW_W + MOD_W;

  logic [ADDR_W-1:0]  local_idx;
  logic               pos_ok;
  logic               range_ok;
  logic [MOD_W-1:0]   mate_idx;
  logic [NUM_MOD-1:0] self_hot;
  logic [NUM_MOD-1:0] mate_hot;

  always_comb begin
    if (layout == LAYOUT_FLAT) local_idx = addr;
    else                       local_idx = {1'b0, addr[ADDR_W-1:1]};
  end

  assign pos_ok   = (layout == LAYOUT_FLAT) ||
                    (layout_split(layout) && (addr[0] == odd_sel));
  assign range_ok = (local_idx >> SPAN_W) == '0;
  assign mod_idx  = local_idx[MOD_W-1:0];
  assign row_idx  = local_idx[SPAN_W-1:MOD_W];
  assign mate_idx = mod_idx ^ MOD_W'(1);

  assign hit = pos_ok && range_ok && slots[mod_idx];

  generate
    for (genvar m = 0; m < NUM_MOD; m++) begin : g_hot
      assign self_hot[m] = (mod_idx == MOD_W'(m));
      assign mate_hot[m] = (mate_idx == MOD_W'(m)) && slots[m] &&
                           (layout == LAYOUT_FOUR);
    end
  endgenerate

  assign launch = self_hot | mate_hot;

endmodule

// File: rtl/ibc_store.sv
module ibc_store #(
  parameter int WORD_W = 37,
  parameter int ROWS   = 16,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [WORD_W-1:0] wword,
  output logic [WORD_W-1:0] rword
);

  logic [WORD_W-1:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) cells[row] <= wword;
      rword <= cells[row];
    end
  end

endmodule

// File: rtl/ibc_cycle_timer.sv
module ibc_cycle_timer #(
  parameter int CYC_LEN = 6,
  localparam int CNT_W  = $clog2(CYC_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                remain <= '0;
    else if (start)         remain <= CNT_W'(CYC_LEN - 1);
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);

endmodule

// File: rtl/ilv_bank_ctrl.sv
module ilv_bank_ctrl
  import ibc_pkg::*;
#(
  parameter int DATA_W  = 36,
  parameter int ADDR_W  = 12,
  parameter int ROWS    = 16,
  parameter int NUM_MOD = 4,
  parameter int ACC_DLY = 3,
  parameter int CYC_LEN = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          cfg_mode,
  input  logic                cfg_odd,
  input  logic [NUM_MOD-1:0]  cfg_slots,
  input  logic                bus_req,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_par_flip,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_ack,
  output logic                bus_perr
);

  localparam int ROW_W  = $clog2(ROWS);
  localparam int MOD_W  = $clog2(NUM_MOD);
  localparam int WORD_W = DATA_W + 1;
  localparam int DLY_W  = $clog2(ACC_DLY + 1);

  logic               map_hit;
  logic [MOD_W-1:0]   map_mod;
  logic [ROW_W-1:0]   map_row;
  logic [NUM_MOD-1:0] map_launch;
  logic [NUM_MOD-1:0] mod_busy;
  logic               acc_fire;
  logic [MOD_W-1:0]   acc_mod;
  logic               eng_act;
  logic [DLY_W-1:0]   eng_cnt;
  logic [MOD_W-1:0]   sel_mod;
  logic               sel_we;
  logic [WORD_W-1:0]  sel_q;
  logic [WORD_W-1:0]  wr_word;
  logic               par_bit;
  logic [WORD_W-1:0]  store_q [NUM_MOD];

  ibc_addr_map #(
    .ADDR_W (ADDR_W),
    .ROWS   (ROWS),
    .NUM_MOD(NUM_MOD)
  ) u_map (
    .layout (layout_e'(cfg_mode)),
    .odd_sel(cfg_odd),
    .slots  (cfg_slots),
    .addr   (bus_addr),
    .hit    (map_hit),
    .mod_idx(map_mod),
    .row_idx(map_row),
    .launch (map_launch)
  );

  assign acc_fire = bus_req && !eng_act && map_hit && ((map_launch & mod_busy) == '0);
  assign acc_mod  = map_mod;

  assign par_bit = (~^bus_wdata) ^ bus_par_flip;
  assign wr_word = {par_bit, bus_wdata};

  generate
    for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
      logic go;
      assign go = acc_fire && map_launch[m];

      ibc_store #(
        .WORD_W(WORD_W),
        .ROWS  (ROWS)
      ) u_store (
        .clk  (clk),
        .en   (go),
        .we   (go && bus_we && (map_mod == MOD_W'(m))),
        .row  (map_row),
        .wword(wr_word),
        .rword(store_q[m])
      );

      ibc_cycle_timer #(
        .CYC_LEN(CYC_LEN)
      ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .start(go),
        .busy (mod_busy[m])
      );
    end
  endgenerate

  assign sel_q = store_q[sel_mod];

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_act   <= 1'b0;
      eng_cnt   <= '0;
      sel_mod   <= '0;
      sel_we    <= 1'b0;
      bus_ack   <= 1'b0;
      bus_perr  <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack  <= 1'b0;
      bus_perr <= 1'b0;
      if (acc_fire) begin
        eng_act <= 1'b1;
        eng_cnt <= DLY_W'(ACC_DLY - 1);
        sel_mod <= map_mod;
        sel_we  <= bus_we;
      end else if (eng_act) begin
        if (eng_cnt == '0) begin
          eng_act   <= 1'b0;
          bus_ack   <= 1'b1;
          bus_rdata <= sel_q[DATA_W-1:0];
          bus_perr  <= !sel_we && !(^sel_q);
        end else begin
          eng_cnt <= eng_cnt - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ilv_bank_ctrl_chk.sv
module ilv_bank_ctrl_chk #(
  parameter int ADDR_W  = 12,
  parameter int NUM_MOD = 4,
  parameter int ACC_DLY = 3,
  localparam int MOD_W  = $clog2(NUM_MOD),
  localparam int LAT_W  = $clog2(ACC_DLY + 1) + 1
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         cfg_mode,
  input logic               cfg_odd,
  input logic [NUM_MOD-1:0] cfg_slots,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_ack,
  input logic               bus_perr,
  input logic               acc_fire,
  input logic [MOD_W-1:0]   acc_mod
);

  logic             lat_act;
  logic [LAT_W-1:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_act <= 1'b0;
      lat_cnt <= '0;
    end else if (acc_fire) begin
      lat_act <= 1'b1;
      lat_cnt <= '0;
    end else if (lat_act) begin
      if (lat_cnt == LAT_W'(ACC_DLY)) lat_act <= 1'b0;
      else                            lat_cnt <= lat_cnt + 1'b1;
    end
  end

  // R5
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  // R5
  ack_on_time_chk: assert property (@(posedge clk) disable iff (rst)
    (lat_act && lat_cnt == LAT_W'(ACC_DLY)) |-> bus_ack);

  // R5
  ack_only_due_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> (lat_act && lat_cnt == LAT_W'(ACC_DLY)));

  // R5
  one_phase_chk: assert property (@(posedge clk) disable iff (rst)
    acc_fire |=> !acc_fire);

  // R7
  perr_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
    bus_perr |-> bus_ack);

  // R2
  strap_match_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_fire && cfg_mode != 2'd0) |-> (cfg_mode != 2'd3 && bus_addr[0] == cfg_odd));

  // R4
  slot_present_chk: assert property (@(posedge clk) disable iff (rst)
    acc_fire |-> cfg_slots[acc_mod]);

endmodule

bind ilv_bank_ctrl ilv_bank_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .NUM_MOD(NUM_MOD),
  .ACC_DLY(ACC_DLY)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_mode (cfg_mode),
  .cfg_odd  (cfg_odd),
  .cfg_slots(cfg_slots),
  .bus_addr (bus_addr),
  .bus_ack  (bus_ack),
  .bus_perr (bus_perr),
  .acc_fire (acc_fire),
  .acc_mod  (acc_mod)
);

// File: tb/ilv_bank_ctrl_tb.sv
module ilv_bank_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W  = 36;
  localparam int ADDR_W  = 12;
  localparam int ROWS    = 16;
  localparam int NUM_MOD = 4;
  localparam int ACC_DLY = 3;
  localparam int CYC_LEN = 6;
  localparam int WAIT_NO = 20;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [1:0]         cfg_mode = 2'd0;
  logic               cfg_odd = 1'b0;
  logic [NUM_MOD-1:0] cfg_slots = '1;
  logic               bus_req = 1'b0;
  logic [ADDR_W-1:0]  bus_addr = '0;
  logic               bus_we = 1'b0;
  logic [DATA_W-1:0]  bus_wdata = '0;
  logic               bus_par_flip = 1'b0;
  logic [DATA_W-1:0]  bus_rdata;
  logic               bus_ack;
  logic               bus_perr;

  int n_total = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit live    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_bank_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ROWS(ROWS),
    .NUM_MOD(NUM_MOD), .ACC_DLY(ACC_DLY), .CYC_LEN(CYC_LEN)
  ) u_dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_odd(cfg_odd),
    .cfg_slots(cfg_slots), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_par_flip(bus_par_flip),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_perr(bus_perr)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [DATA_W:0] ref_mem [int];
  int  eng_left = 0;
  int  free_at [NUM_MOD];
  int  edge_no = 0;
  bit  m_ack = 0;
  logic [DATA_W-1:0] m_rd = '0;
  bit  m_rd_known = 1;
  bit  m_perr = 0;
  bit  m_perr_known = 1;
  logic [DATA_W-1:0] p_rd;
  bit  p_rd_known, p_perr, p_perr_known;

  always @(posedge clk) begin
    edge_no++;
    if (rst) begin
      eng_left = 0;
      for (int i = 0; i < NUM_MOD; i++) free_at[i] = 0;
      m_ack = 0; m_rd = '0; m_rd_known = 1; m_perr = 0; m_perr_known = 1;
    end else begin
      bit idle;
      idle  = (eng_left == 0);
      m_ack = 0;
      m_perr = 0;
      m_perr_known = 1;
      if (!idle) begin
        eng_left--;
        if (eng_left == 0) begin
          m_ack = 1;
          m_rd = p_rd; m_rd_known = p_rd_known;
          m_perr = p_perr; m_perr_known = p_perr_known;
        end
      end
      if (idle && bus_req) begin
        int li, md, pm;
        bit own, four;
        li   = (cfg_mode == 2'd0) ? int'(bus_addr) : int'(bus_addr) / 2;
        own  = (cfg_mode == 2'd0) ||
               ((cfg_mode == 2'd1 || cfg_mode == 2'd2) && bus_addr[0] == cfg_odd);
        own  = own && (li < NUM_MOD * ROWS);
        md   = li % NUM_MOD;
        pm   = md ^ 1;
        own  = own && cfg_slots[md];
        four = (cfg_mode == 2'd2) && cfg_slots[pm];
        if (own && edge_no >= free_at[md] && (!four || edge_no >= free_at[pm])) begin
          eng_left = ACC_DLY;
          free_at[md] = edge_no + CYC_LEN;
          if (four) free_at[pm] = edge_no + CYC_LEN;
          if (ref_mem.exists(li)) begin
            p_rd = ref_mem[li][DATA_W-1:0];
            p_rd_known = 1;
            p_perr = !bus_we && ((^ref_mem[li]) == 1'b0);
            p_perr_known = 1;
          end else begin
            p_rd_known = 0;
            p_perr = 0;
            p_perr_known = bus_we;
          end
          if (bus_we)
            ref_mem[li] = {(~^bus_wdata) ^ bus_par_flip, bus_wdata};
        end
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (live) begin
      chk(bus_ack === m_ack, "R5 ack timing", 64'(bus_ack), 64'(m_ack));
      if (m_ack && m_rd_known)
        chk(bus_rdata === m_rd, "R6 rdata vs model", 64'(bus_rdata), 64'(m_rd));
      if (m_ack && m_perr_known)
        chk(bus_perr === m_perr, "R7 perr vs model", 64'(bus_perr), 64'(m_perr));
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 50000);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic access(input logic [ADDR_W-1:0] a, input bit we, input logic [DATA_W-1:0] d,
                        input bit flip, input int maxw,
                        output bit got, output logic [DATA_W-1:0] rd, output bit pe, output int lat);
    bus_addr = a; bus_we = we; bus_wdata = d; bus_par_flip = flip; bus_req = 1'b1;
    got = 0; lat = 0; rd = '0; pe = 0;
    while (lat < maxw && !got) begin
      @(negedge clk);
      lat++;
      if (bus_ack) begin
        got = 1; rd = bus_rdata; pe = bus_perr;
      end
    end
    bus_req = 1'b0; bus_we = 1'b0; bus_par_flip = 1'b0;
  endtask

  function automatic logic [DATA_W-1:0] pat(input int i);
    return {4'(i + 3), 32'hC0DE_0000 + 32'(i * 32'h1111)};
  endfunction

  initial begin
    bit got, pe;
    logic [DATA_W-1:0] rd;
    int lat;

    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(bus_ack === 1'b0 && bus_perr === 1'b0, "R1 reset ack/perr", {bus_ack, bus_perr}, 0);
    rst = 1'b0;
    @(negedge clk);
    live = 1;
    chk(bus_rdata === '0 && bus_ack === 1'b0, "R1 after reset", 64'(bus_rdata), 0);

    // flat mode, all slots
    cfg_mode = 2'd0; cfg_odd = 1'b0; cfg_slots = 4'b1111;
    access(0, 1, pat(0), 0, WAIT_NO, got, rd, pe, lat);
    chk(got && lat == ACC_DLY + 1, "R5 first latency", 64'(lat), 64'(ACC_DLY + 1));
    access(1, 1, pat(1), 0, WAIT_NO, got, rd, pe, lat);
    chk(got && lat == ACC_DLY + 1, "R11 other module back-to-back", 64'(lat), 64'(ACC_DLY + 1));
    for (int i = 2; i < 8; i++) access(ADDR_W'(i), 1, pat(i), 0, WAIT_NO, got, rd, pe, lat);

    access(0, 0, '0, 0, WAIT_NO, got, rd, pe, lat);
    chk(got && rd === pat(0), "R6 read addr0", 64'(rd), 64'(pat(0)));
    chk(pe === 1'b0, "R7 clean read no perr", 64'(pe), 0);
    access(4, 0, '0, 0, WAIT_NO, got, rd, pe, lat);
    chk(got && lat == CYC_LEN, "R8 same module recovery", 64'(lat), 64'(CYC_LEN));
    chk(rd === pat(4), "R6 read addr4", 64'(rd), 64'(pat(4)));

    // R3 / R10: out-of-range index
    access(ADDR_W'(NUM_MOD * ROWS), 1, 36'hBAD, 0, WAIT_NO, got, rd, pe, lat);
    chk(!got, "R3 out of range no ack", 64'(got), 0);
    access(0, 0, '0, 0, WAIT_NO, got, rd, pe, lat);
    chk(got && rd === pat(0), "R10 no alias write", 64'(rd), 64'(pat(0)));

    // R4: absent slot
    cfg_slots = 4'b1101;
    access(1, 1, 36'hBAD, 0, WAIT_NO, got, rd, pe, lat);
    chk(!got, "R4 absent slot no ack", 64'(got), 0);
    cfg_slots = 4'b1111;
    access(1, 0, '0, 0, WAIT_NO, got, rd, pe, lat);
    chk(got && rd === pat(1), "R4 slot untouched", 64'(rd), 64'(pat(1)));

    // R7: inverted parity
    access(5, 1, 36'h5_A5A5_A5A5, 1, WAIT_NO, got, rd, pe, lat);
    chk(got && pe === 1'b0, "R7 write no perr", 64'(pe), 0);
    access(5, 0, '0, 0, WAIT_NO, got, rd, pe, lat);
    chk(got && pe === 1'b1, "R7 bad parity flagged", 64'(pe), 1);
    chk(rd === 36'h5_A5A5_A5A5, "R7 data with perr", 64'(rd), 64'h5_A5A5_A5A5);

    // two-way even
    cfg_mode = 2'd1; cfg_odd = 1'b0;
    access(2, 0, '0, 0, WAIT_NO, got, rd, pe, lat);
    chk(got && rd === pat(1), "R3 two-way addr2 -> index1", 64'(rd), 64'(pat(1)));
    access(3, 0, '0, 0, WAIT_NO, got, rd, pe, lat);
    chk(!got, "R2 odd addr refused when even", 64'(got), 0);
    access(1, 1, 36'hBAD, 0, WAIT_NO, got, rd, pe, lat);
    chk(!got, "R10 refused write no ack", 64'(got), 0);
    access(0, 0, '0, 0, WAIT_NO, got, rd, pe, lat);
    chk(got && rd === pat(0), "R10 refused write left word", 64'(rd), 64'(pat(0)));
    access(2, 0, '0, 0, WAIT_NO, got, rd, pe, lat);
    chk(got && lat == ACC_DLY + 1, "R9 two-way partner free", 64'(lat), 64'(ACC_DLY + 1));

    // two-way odd
    cfg_odd = 1'b1;
    access(3, 0, '0, 0, WAIT_NO, got, rd, pe, lat);
    chk(got && rd === pat(1), "R2 odd strap addr3", 64'(rd), 64'(pat(1)));
    access(9, 0, '0, 0, WAIT_NO, got, rd, pe, lat);
    chk(got && rd === pat(4), "R3 two-way odd addr9 -> index4", 64'(rd), 64'(pat(4)));

    // off
    cfg_mode = 2'd3;
    access(0, 0, '0, 0, WAIT_NO, got, rd, pe, lat);
    chk(!got, "R2 off mode owns nothing", 64'(got), 0);

    // four-way even
    cfg_mode = 2'd2; cfg_odd = 1'b0;
    access(0, 0, '0, 0, WAIT_NO, got, rd, pe, lat);
    chk(got && rd === pat(0), "R3 four-way addr0", 64'(rd), 64'(pat(0)));
    access(2, 0, '0, 0, WAIT_NO, got, rd, pe, lat);
    chk(got && lat == CYC_LEN, "R9 partner busy in four-way", 64'(lat), 64'(CYC_LEN));
    chk(rd === pat(1), "R6 four-way partner word", 64'(rd), 64'(pat(1)));
    access(4, 0, '0, 0, WAIT_NO, got, rd, pe, lat);
    chk(got && lat == ACC_DLY + 1, "R11 other pair free", 64'(lat), 64'(ACC_DLY + 1));
    chk(rd === pat(2), "R3 four-way addr4 -> index2", 64'(rd), 64'(pat(2)));
    access(1, 0, '0, 0, WAIT_NO, got, rd, pe, lat);
    chk(!got, "R2 four-way odd addr refused", 64'(got), 0);

    repeat (CYC_LEN + 2) @(negedge clk);
    live = 0;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule